// File: doc/BRIEF.md
# Indexed Host Register Window

This block is the host-facing front end of a video controller that sits on an 8-bit microprocessor bus. The host sees only two byte locations. The first is an index. The second is a data window into a bank of internal registers, and the index picks which one. The internal bank holds 128 bytes. The top bit of the index byte states whether the next data-window access is a read or a write.

Host reads must finish in a single bus cycle. For that reason, writing an index with the read flag set fetches the selected register into the data window straight away, so a later read of the window returns it with no wait. A data-window write with the write flag set updates the selected register. It also raises a one-cycle update pulse that carries the index and the byte. Every host write, to any address, is latched along with the low five address bits in a capture buffer, so that slower logic can consume it later. Bus strobes are sampled in the core clock domain. Each assertion of the enable counts as one access.

Top module: `hwin_top`

## Requirements
- R1: After reset, the index reads back as 0x00, the direction is write, the data window reads 0x00, every bank entry is 0x00, the error flag is low, and no update or capture pulse is raised.
- R2: A host write to address 0 (all five address bits compared) sets the index to data bits 6:0 and the direction to bit 7, where 1 means read and 0 means write. A host read of address 0 returns that byte.
- R3: With the direction at write, a host write to address 1 stores the byte in the bank entry the index selects and places it in the data window. In the clock after the edge that starts the access, upd_valid is high for exactly one cycle, with upd_idx equal to the index and upd_data equal to the byte.
- R4: An index write with bit 7 set loads the selected bank entry into the data window on the same edge. A host read of address 1 then returns that value, including for index 127 and for entries never written (0x00).
- R5: With the direction at read, a host write to address 1 changes no bank entry and leaves the data window unchanged. It raises no update pulse and sets err_sticky, which then stays high until reset.
- R6: Every host write latches all five address bits into cap_addr and the byte into cap_data in the cycle after the edge that starts it, and raises cap_new for that one cycle.
- R7: An access is taken once, on the first clock in which chip select and enable are both high. Holding them high for more cycles yields no further update or capture pulse.
- R8: A write to any address other than 0 and 1 is captured but leaves the index, the direction and the window unchanged. A read of such an address returns 0x00.
- R9: Host reads have no side effects. Reading the data window repeatedly returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Chip select for the two-location window |
| bus_rw | input | 1 | Bus direction, 1 = read, 0 = write |
| bus_en | input | 1 | Clock-qualified bus enable |
| bus_addr | input | 5 | Low bus address bits |
| bus_wdata | input | 8 | Write data from the host |
| bus_rdata | output | 8 | Read data to the host |
| upd_valid | output | 1 | One-cycle pulse for a committed register write |
| upd_idx | output | 7 | Index of the committed register write |
| upd_data | output | 8 | Byte of the committed register write |
| cap_new | output | 1 | One-cycle pulse for a newly captured host write |
| cap_addr | output | 5 | Address of the last host write |
| cap_data | output | 8 | Byte of the last host write |
| err_sticky | output | 1 | Set by a window write while the direction is read |

## Verification
Register state changes on the clock edge that starts an access. The update and capture pulses are high during the following cycle, and read data is combinational from the registers. A driver task therefore sets the bus lines at a falling edge and lets one rising edge pass. It then compares read data, the capture outputs and the error flag at the next falling edge. Expected update pulses go into a queue. A monitor samples at every falling edge, pops the queue on each pulse, and reports any pulse that nothing expected. In this way, held enables and ignored writes are judged by the absence of extra pulses.

// File: rtl/hwin_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the indexed host register window.
// Assumes one access class per bus access, chosen by the decoder.
package hwin_pkg;
    // Kind of host access taken on the current clock
    typedef enum logic [2:0] {
        ACC_NONE   = 3'd0,
        ACC_IDX_WR = 3'd1,
        ACC_DAT_WR = 3'd2,
        ACC_OTH_WR = 3'd3,
        ACC_READ   = 3'd4
    } acc_kind_e;
endpackage

// File: rtl/hwin_decode.sv
`timescale 1ns/1ps
// Module: hwin_decode
// Turns host strobes into a single-clock access class. An access is taken
// on the first clock where chip select and enable are both high.
// Assumes the host holds address, data and direction stable while enabled.
module hwin_decode
    import hwin_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int IDX_LOC = 0,
    parameter int DAT_LOC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_rw,
    input  logic              bus_en,
    input  logic [ADDR_W-1:0] bus_addr,
    output acc_kind_e         kind
);
    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(IDX_LOC);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DAT_LOC);

    logic live;
    logic live_q;
    logic stb;

    assign live = bus_cs & bus_en;
    assign stb  = live & ~live_q;

    // Remember whether the bus was selected on the previous clock
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= live;
    end

    // Classify the access on its first clock only
    always_comb begin
        kind = ACC_NONE;
        if (stb) begin
            if (bus_rw)                kind = ACC_READ;
            else if (bus_addr == IDX_A) kind = ACC_IDX_WR;
            else if (bus_addr == DAT_A) kind = ACC_DAT_WR;
            else                        kind = ACC_OTH_WR;
        end
    end

    AST_ONE_TAKE_PER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_NONE) |=> (kind == ACC_NONE)); // R7
endmodule

// File: rtl/hwin_bank.sv
`timescale 1ns/1ps
// Module: hwin_bank
// The internal register bank behind the window: one write port, one
// combinational read port. Assumes at most one write per clock.
module hwin_bank #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int NREG = 1 << IDX_W;

    logic [DATA_W-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Hold one register, cleared on reset, loaded when selected
        always_ff @(posedge clk) begin
            if (!rst_n)                               mem[g] <= '0;
            else if (we && widx == IDX_W'(g))         mem[g] <= wdata;
        end
    end

    // Read port: select the addressed register
    assign rdata = mem[ridx];

    AST_BANK_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ridx == widx) |=> (rdata == $past(wdata))); // R3
endmodule

// File: rtl/hwin_capture.sv
`timescale 1ns/1ps
// Module: hwin_capture
// Latches each host write with its address so slower logic can read it
// later. Assumes take is a single-clock strobe.
module hwin_capture #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic              cap_new
);
    // Hold the newest write and flag it for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
            cap_new  <= 1'b0;
        end else begin
            cap_new <= take;
            if (take) begin
                cap_addr <= addr;
                cap_data <= data;
            end
        end
    end

    AST_CAP_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cap_addr == $past(addr) && cap_data == $past(data))); // R6
    AST_CAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(cap_addr) && $stable(cap_data) && !cap_new)); // R6
endmodule

// File: rtl/hwin_top.sv
`timescale 1ns/1ps
// Module: hwin_top
// Two-location host window into a bank of internal registers: an index
// byte (top bit = direction of next window access) and a data window.
// A read-direction index prefetches the selected entry into the window,
// so host reads are served from a register with no wait.
// Assumes DATA_W == IDX_W + 1 and strobes already in the core clock domain.
module hwin_top
    import hwin_pkg::*;
#(
    parameter int IDX_W   = 7,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 5,
    parameter int IDX_LOC = 0,
    parameter int DAT_LOC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_rw,
    input  logic              bus_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              upd_valid,
    output logic [IDX_W-1:0]  upd_idx,
    output logic [DATA_W-1:0] upd_data,
    output logic              cap_new,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic              err_sticky
);
    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(IDX_LOC);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DAT_LOC);

    acc_kind_e         kind;
    logic [IDX_W-1:0]  idx_q;
    logic              dir_rd_q;
    logic [DATA_W-1:0] win_q;
    logic [IDX_W-1:0]  bank_ridx;
    logic [DATA_W-1:0] bank_rdata;
    logic              bank_we;
    logic              wr_take;

    hwin_decode #(
        .ADDR_W (ADDR_W),
        .IDX_LOC(IDX_LOC),
        .DAT_LOC(DAT_LOC)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_cs  (bus_cs),
        .bus_rw  (bus_rw),
        .bus_en  (bus_en),
        .bus_addr(bus_addr),
        .kind    (kind)
    );

    // Prefetch looks up the new index while it is being written
    assign bank_ridx = (kind == ACC_IDX_WR) ? bus_wdata[IDX_W-1:0] : idx_q;
    assign bank_we   = (kind == ACC_DAT_WR) && !dir_rd_q;
    assign wr_take   = (kind == ACC_IDX_WR) || (kind == ACC_DAT_WR) || (kind == ACC_OTH_WR);

    hwin_bank #(
        .IDX_W (IDX_W),
        .DATA_W(DATA_W)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bank_we),
        .widx (idx_q),
        .wdata(bus_wdata),
        .ridx (bank_ridx),
        .rdata(bank_rdata)
    );

    hwin_capture #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (wr_take),
        .addr    (bus_addr),
        .data    (bus_wdata),
        .cap_addr(cap_addr),
        .cap_data(cap_data),
        .cap_new (cap_new)
    );

    // Index, direction and window registers, updated by host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            dir_rd_q <= 1'b0;
            win_q    <= '0;
        end else if (kind == ACC_IDX_WR) begin
            idx_q    <= bus_wdata[IDX_W-1:0];
            dir_rd_q <= bus_wdata[DATA_W-1];
            if (bus_wdata[DATA_W-1]) win_q <= bank_rdata;
        end else if (bank_we) begin
            win_q <= bus_wdata;
        end
    end

    // Update pulse for committed writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_idx   <= '0;
            upd_data  <= '0;
        end else begin
            upd_valid <= bank_we;
            if (bank_we) begin
                upd_idx  <= idx_q;
                upd_data <= bus_wdata;
            end
        end
    end

    // Sticky error for window writes in read direction
    always_ff @(posedge clk) begin
        if (!rst_n)                                     err_sticky <= 1'b0;
        else if (kind == ACC_DAT_WR && dir_rd_q)        err_sticky <= 1'b1;
    end

    // Host read mux, served from registers only
    always_comb begin
        if (bus_addr == IDX_A)      bus_rdata = {dir_rd_q, idx_q};
        else if (bus_addr == DAT_A) bus_rdata = win_q;
        else                        bus_rdata = '0;
    end

    AST_PREFETCH_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rd_q && kind != ACC_IDX_WR) |-> (win_q == bank_rdata)); // R4
    AST_BAD_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_DAT_WR && dir_rd_q) |=> (!upd_valid && err_sticky && $stable(win_q))); // R5
    AST_ERR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky); // R5
    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid); // R3
    AST_OTHER_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_OTH_WR || kind == ACC_READ) |=> ($stable(idx_q) && $stable(dir_rd_q) && $stable(win_q))); // R8
endmodule

// File: tb/tb_hwin_top.sv
`timescale 1ns/1ps
// Scoreboard bench for hwin_top: the driver pushes expected update pulses,
// a monitor pops and compares them as they appear.
module tb_hwin_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_rw = 1'b1;
    logic       bus_en = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       upd_valid;
    logic [6:0] upd_idx;
    logic [7:0] upd_data;
    logic       cap_new;
    logic [4:0] cap_addr;
    logic [7:0] cap_data;
    logic       err_sticky;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    logic [14:0] exp_q [$];
    logic [7:0]  mdl_bank [128];
    logic [6:0]  mdl_idx;
    logic        mdl_dir;
    logic [7:0]  mdl_win;
    logic        mdl_err;

    always #2.5 clk = ~clk;

    hwin_top dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rw(bus_rw),
        .bus_en(bus_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .upd_valid(upd_valid), .upd_idx(upd_idx),
        .upd_data(upd_data), .cap_new(cap_new), .cap_addr(cap_addr),
        .cap_data(cap_data), .err_sticky(err_sticky)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: every update pulse must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && upd_valid) begin
            vectors++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R3/R5/R7: actual unexpected pulse %0h/%0h expected none", upd_idx, upd_data);
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                if ({upd_idx, upd_data} !== e) begin
                    fails++;
                    $display("FAIL R3: actual %0h expected %0h", {upd_idx, upd_data}, e);
                end
            end
        end
    end

    // Driver: one host write, enable held for 'hold' cycles
    task automatic host_write(input logic [4:0] a, input logic [7:0] d, input int hold);
        @(negedge clk);
        bus_cs = 1'b1; bus_rw = 1'b0; bus_addr = a; bus_wdata = d; bus_en = 1'b1;
        if (a == 5'd0) begin
            mdl_idx = d[6:0];
            mdl_dir = d[7];
            if (d[7]) mdl_win = mdl_bank[d[6:0]];
        end else if (a == 5'd1) begin
            if (mdl_dir) mdl_err = 1'b1;
            else begin
                mdl_bank[mdl_idx] = d;
                mdl_win = d;
                exp_q.push_back({mdl_idx, d});
            end
        end
        @(negedge clk);
        check("R6 cap_new", {15'd0, cap_new}, 16'd1);
        check("R6 cap_addr", {11'd0, cap_addr}, {11'd0, a});
        check("R6 cap_data", {8'd0, cap_data}, {8'd0, d});
        check("R5 err", {15'd0, err_sticky}, {15'd0, mdl_err});
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            check("R7 no second capture", {15'd0, cap_new}, 16'd0);
        end
        bus_en = 1'b0; bus_cs = 1'b0;
    endtask

    task automatic host_read(input logic [4:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_cs = 1'b1; bus_rw = 1'b1; bus_addr = a; bus_en = 1'b1;
        @(negedge clk);
        check(req, {8'd0, bus_rdata}, {8'd0, exp});
        bus_en = 1'b0; bus_cs = 1'b0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) mdl_bank[i] = 8'h00;
        mdl_idx = '0; mdl_dir = 1'b0; mdl_win = '0; mdl_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_addr = 5'd0; @(negedge clk);
        check("R1 index", {8'd0, bus_rdata}, 16'd0);
        bus_addr = 5'd1; @(negedge clk);
        check("R1 window", {8'd0, bus_rdata}, 16'd0);
        check("R1 err", {15'd0, err_sticky}, 16'd0);
        check("R1 pulses", {14'd0, upd_valid, cap_new}, 16'd0);
        // R2 index write/readback
        host_write(5'd0, 8'h05, 1);
        host_read(5'd0, 8'h05, "R2 index readback");
        // R3 committed write
        host_write(5'd1, 8'hA5, 1);
        host_read(5'd1, 8'hA5, "R3 window after write");
        // R4 prefetch, R9 repeated reads
        host_write(5'd0, 8'h85, 1);
        host_read(5'd0, 8'h85, "R2 read flag readback");
        host_read(5'd1, 8'hA5, "R4 prefetch");
        host_read(5'd1, 8'hA5, "R9 second read same");
        host_write(5'd0, 8'h8A, 1);
        host_read(5'd1, 8'h00, "R4 unwritten entry");
        // R5 ignored write
        host_write(5'd1, 8'h3C, 1);
        host_read(5'd1, 8'h00, "R5 window unchanged");
        host_write(5'd0, 8'h8A, 1);
        host_read(5'd1, 8'h00, "R5 bank unchanged");
        // R3/R4 several entries incl. boundary 127
        for (int k = 0; k < 4; k++) begin
            logic [6:0] ix;
            ix = (k == 3) ? 7'd127 : 7'(k * 37 + 1);
            host_write(5'd0, {1'b0, ix}, 1);
            host_write(5'd1, 8'(8'h11 * (k + 3)), 1);
        end
        for (int k = 0; k < 4; k++) begin
            logic [6:0] ix;
            ix = (k == 3) ? 7'd127 : 7'(k * 37 + 1);
            host_write(5'd0, {1'b1, ix}, 1);
            host_read(5'd1, mdl_bank[ix], "R4 prefetch sweep");
        end
        // R8 other addresses
        host_write(5'd7, 8'h5A, 1);
        host_read(5'd7, 8'h00, "R8 other address reads zero");
        host_read(5'd0, {mdl_dir, mdl_idx}, "R8 index unchanged");
        host_read(5'd1, mdl_win, "R8 window unchanged");
        host_write(5'd21, 8'hC3, 2);
        // R7 held enable, single commit
        host_write(5'd0, 8'h40, 1);
        host_write(5'd1, 8'h77, 6);
        host_write(5'd0, 8'hC0, 1);
        host_read(5'd1, 8'h77, "R7 single commit value");
        check("R5 err stays", {15'd0, err_sticky}, 16'd1);
        repeat (3) @(negedge clk);
        check("R3/R7 all pulses seen", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule